// File: doc/BRIEF.md
# Biphase-Mark Stereo Audio Transmitter

The block serialises stereo audio samples into 32-slot subframes and drives a single line with biphase-mark code. Each subframe opens with a synchronising preamble that breaks the coding rule. The preamble is followed by auxiliary bits, a 20-bit audio field that carries the sample in its upper 16 slots, and then a validity flag, a user-data bit, a channel-status bit and an even-parity bit. Subframes alternate left and right. A counter marks the first subframe of every block of `BLK_LEN` subframes with its own preamble.

The block runs on a clock at the half-cell rate, so one subframe lasts 64 cycles. A strobe `take_o` is high in the last cycle of every subframe. The surrounding logic presents that subframe's sample, flags and serial bits during the strobe, and `right_o` and `blkst_o` tell it which subframe is next. Both the raw sample and the concealed sample come into the block, and a 4-bit configuration register picks between them. The same register can also force the line low and can route the error and interpolation flags into the auxiliary slots.

Top module: `bmc_audio_tx`

## Requirements
- R1: While reset is held, `line_o` is 0, `take_o` is 1, `right_o` is 0 and `blkst_o` is 1. The first subframe after reset is therefore a block-start left subframe, sent from a low line level.
- R2: `take_o` is high for exactly one cycle in every 64. Inputs presented in that cycle form the subframe whose half-cell k appears on `line_o` k+1 cycles later, for k = 0 to 63.
- R3: Half-cells 0 to 7 carry the preamble. Read MSB first as levels from a low starting line, the patterns are 11101000 for a block start, 11100010 for another left subframe and 11100100 for a right subframe. Every level is inverted when the line was high before the preamble.
- R4: Slots 4 to 31 use biphase-mark code. The line toggles at the start of every slot (half-cell 2s) and toggles again at half-cell 2s+1 only for a 1.
- R5: Subframe indices run from 0 to BLK_LEN-1 and then wrap. Index 0 is a block start. Even indices are left and odd indices are right. During `take_o`, `right_o` and `blkst_o` describe the upcoming subframe.
- R6: Slots 8 to 11 are 0. Sample bit 0 goes in slot 12 and sample bit 15 goes in slot 27.
- R7: Configuration bits [1:0] equal to 10 send `cnc_smp`. The values 00 and 01 send `raw_smp`.
- R8: Configuration bits [1:0] equal to 11 hold `line_o` at 0 from the second cycle after that value is stored.
- R9: When configuration bit 3 is 0, slots 4 to 7 are 0. When it is 1, slot 4 is `err_flg`, slot 5 is `itp_flg`, and slots 6 and 7 are 0.
- R10: Slot 28 equals `err_flg` in every data mode.
- R11: Slot 29 carries `user_bit` and slot 30 carries `cstat_bit`.
- R12: Slot 31 makes the count of ones in slots 4 to 31 even.
- R13: `cfg_wdata` is stored when `cfg_we` is high. Sample selection and aux routing use the value stored before the current `take_o` cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Half-cell rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 4 | Configuration value: [1:0] mode, [3] aux flag routing |
| raw_smp | input | SMP_W | Sample taken before concealment |
| cnc_smp | input | SMP_W | Sample taken after concealment, mute and fade |
| err_flg | input | 1 | Uncorrectable-error flag for the sample |
| itp_flg | input | 1 | Interpolation flag for the sample |
| user_bit | input | 1 | Next bit of the subcode user stream |
| cstat_bit | input | 1 | Next channel-status bit |
| take_o | output | 1 | Inputs are captured at the end of this cycle |
| right_o | output | 1 | Upcoming subframe is a right sample |
| blkst_o | output | 1 | Upcoming subframe starts a block |
| line_o | output | 1 | Biphase-mark coded line |

## Verification
The bench sends more than two full blocks. It decodes every half-cell of every subframe and checks it against words built from the requirements. The corner cases are the wrap at block boundaries, extreme sample values (all zeros, all ones, a single set bit) and the edges between modes.

A design that placed the sample in the wrong slots or reversed its bit order would fail the audio field check. A design that leaked the error flag into the aux slots while routing is off would fail the aux check. A design that dropped the validity bit in concealed mode would fail the validity check.

After the line is released from the forced-low mode, it can resume at the high level. A coder that emits preambles with fixed levels, ignoring the line level, fails the preamble check there. An off-by-one in the subframe counter puts the block-start preamble in the wrong place, and a wrong parity bit breaks the parity check.

// File: rtl/bmt_pkg.sv
package bmt_pkg;

    typedef enum logic [1:0] {
        PRE_B = 2'd0,
        PRE_M = 2'd1,
        PRE_W = 2'd2
    } pre_e;

    localparam int unsigned PRE_HC = 8;

    // level sequences from a low start, half-cell 0 in the MSB
    localparam logic [7:0] PAT_B = 8'b1110_1000;
    localparam logic [7:0] PAT_M = 8'b1110_0010;
    localparam logic [7:0] PAT_W = 8'b1110_0100;

    localparam logic [1:0] MODE_PROC = 2'b10;
    localparam logic [1:0] MODE_LOW  = 2'b11;
    localparam int unsigned CFG_W    = 4;
    localparam int unsigned AUX_EN_B = 3;

    function automatic logic [7:0] pre_pattern(input pre_e p);
        case (p)
            PRE_B:   return PAT_B;
            PRE_W:   return PAT_W;
            default: return PAT_M;
        endcase
    endfunction

endpackage

// File: rtl/bmt_frame_pack.sv
module bmt_frame_pack #(
    parameter int unsigned SMP_W = 16,
    parameter int unsigned SLOTS = 32
) (
    input  logic [SMP_W-1:0] smp,
    input  logic             err,
    input  logic             itp,
    input  logic             aux_en,
    input  logic             usr,
    input  logic             cst,
    output logic [SLOTS-1:0] word
);
    localparam int unsigned VAL_S = SLOTS - 4;   // validity slot
    localparam int unsigned LSB_S = VAL_S - SMP_W; // sample MSB-aligned in the audio field

    always_comb begin
        word = '0;
        word[4] = aux_en & err;
        word[5] = aux_en & itp;
        for (int k = 0; k < int'(SMP_W); k++) begin
            word[LSB_S + k] = smp[k];
        end
        word[VAL_S]     = err;
        word[VAL_S + 1] = usr;
        word[VAL_S + 2] = cst;
        word[SLOTS-1]   = ^word[SLOTS-2:4];
    end
endmodule

// File: rtl/bmt_cell_coder.sv
module bmt_cell_coder
    import bmt_pkg::*;
#(
    parameter int unsigned HC_W  = 6,
    parameter int unsigned SLOTS = 32
) (
    input  logic [HC_W-1:0]  hc,
    input  logic [SLOTS-1:0] word,
    input  pre_e             pre,
    input  logic             prev,
    output logic             lvl
);
    logic [7:0]      pat;
    logic [2:0]      pi;
    logic            cur_b;
    logic            bef_b;
    logic [HC_W-2:0] slot;

    always_comb begin
        pat   = pre_pattern(pre);
        pi    = hc[2:0];
        cur_b = pat[3'd7 - pi];
        bef_b = (pi == 3'd0) ? 1'b0 : pat[3'd7 - pi + 3'd1];
        slot  = hc[HC_W-1:1];
        if (hc < HC_W'(PRE_HC)) begin
            lvl = prev ^ cur_b ^ bef_b;
        end else if (!hc[0]) begin
            lvl = ~prev;
        end else begin
            lvl = prev ^ word[slot];
        end
    end
endmodule

// File: rtl/bmc_audio_tx.sv
module bmc_audio_tx
    import bmt_pkg::*;
#(
    parameter int unsigned SMP_W   = 16,
    parameter int unsigned BLK_LEN = 384
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [3:0]       cfg_wdata,
    input  logic [SMP_W-1:0] raw_smp,
    input  logic [SMP_W-1:0] cnc_smp,
    input  logic             err_flg,
    input  logic             itp_flg,
    input  logic             user_bit,
    input  logic             cstat_bit,
    output logic             take_o,
    output logic             right_o,
    output logic             blkst_o,
    output logic             line_o
);
    localparam int unsigned SLOTS = 32;
    localparam int unsigned HALF  = 2 * SLOTS;
    localparam int unsigned HC_W  = $clog2(HALF);
    localparam int unsigned SF_W  = $clog2(BLK_LEN);
    localparam logic [HC_W-1:0] HC_LAST = HC_W'(HALF - 1);
    localparam logic [SF_W-1:0] SF_LAST = SF_W'(BLK_LEN - 1);

    typedef struct packed {
        logic [HC_W-1:0]  hc;
        logic [SF_W-1:0]  sf;
        logic [CFG_W-1:0] cfg;
        logic             line;
        logic [SLOTS-1:0] word;
        pre_e             pre;
    } st_t;

    st_t st_q, st_d;

    logic             take;
    logic [SF_W-1:0]  sf_n;
    logic [HC_W-1:0]  hc_n;
    logic [SLOTS-1:0] word_n;
    logic [SLOTS-1:0] packed_w;
    pre_e             pre_n;
    logic [SMP_W-1:0] smp_sel;
    logic             lvl;

    // exposed for the bound checker
    logic [HC_W-1:0]  hc_q;
    logic [CFG_W-1:0] cfg_q;
    assign hc_q  = st_q.hc;
    assign cfg_q = st_q.cfg;

    assign smp_sel = (st_q.cfg[1:0] == MODE_PROC) ? cnc_smp : raw_smp;

    bmt_frame_pack #(.SMP_W(SMP_W), .SLOTS(SLOTS)) u_pack (
        .smp    (smp_sel),
        .err    (err_flg),
        .itp    (itp_flg),
        .aux_en (st_q.cfg[AUX_EN_B]),
        .usr    (user_bit),
        .cst    (cstat_bit),
        .word   (packed_w)
    );

    // sequencing: position, block count and the word for the next half-cell
    always_comb begin
        take   = (st_q.hc == HC_LAST);
        sf_n   = (st_q.sf == SF_LAST) ? '0 : st_q.sf + 1'b1;
        hc_n   = st_q.hc + 1'b1;
        word_n = st_q.word;
        pre_n  = st_q.pre;
        if (take) begin
            hc_n   = '0;
            word_n = packed_w;
            pre_n  = (sf_n == '0) ? PRE_B : (sf_n[0] ? PRE_W : PRE_M);
        end
    end

    bmt_cell_coder #(.HC_W(HC_W), .SLOTS(SLOTS)) u_coder (
        .hc   (hc_n),
        .word (word_n),
        .pre  (pre_n),
        .prev (st_q.line),
        .lvl  (lvl)
    );

    always_comb begin
        st_d      = st_q;
        st_d.hc   = hc_n;
        st_d.word = word_n;
        st_d.pre  = pre_n;
        if (take) begin
            st_d.sf = sf_n;
        end
        if (cfg_we) begin
            st_d.cfg = cfg_wdata;
        end
        st_d.line = (st_q.cfg[1:0] == MODE_LOW) ? 1'b0 : lvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.hc   <= HC_LAST;
            st_q.sf   <= SF_LAST;
            st_q.cfg  <= '0;
            st_q.line <= 1'b0;
            st_q.word <= '0;
            st_q.pre  <= PRE_B;
        end else begin
            st_q <= st_d;
        end
    end

    assign take_o  = take;
    assign right_o = sf_n[0];
    assign blkst_o = (sf_n == '0);
    assign line_o  = st_q.line;

endmodule

// File: rtl/bmc_audio_tx_chk.sv
module bmc_audio_tx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       take_o,
    input logic       right_o,
    input logic       blkst_o,
    input logic       line_o,
    input logic [5:0] hc,
    input logic [1:0] mode
);
    logic [5:0] gap_q;
    logic       seen_q;
    logic       lastr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q   <= '0;
            seen_q  <= 1'b0;
            lastr_q <= 1'b0;
        end else if (take_o) begin
            gap_q   <= '0;
            seen_q  <= 1'b1;
            lastr_q <= right_o;
        end else begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // R2
    take_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (take_o == (gap_q == 6'd63)));

    // R5
    lr_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && seen_q) |-> (right_o != lastr_q));

    // R5
    block_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && blkst_o) |-> !right_o);

    // R4
    cell_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hc >= 6'd8 && !hc[0] && mode != 2'b11 && $past(mode) != 2'b11)
        |-> (line_o != $past(line_o)));

    // R8
    line_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11 && $past(mode) == 2'b11) |-> !line_o);

endmodule

bind bmc_audio_tx bmc_audio_tx_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .take_o  (take_o),
    .right_o (right_o),
    .blkst_o (blkst_o),
    .line_o  (line_o),
    .hc      (hc_q),
    .mode    (cfg_q[1:0])
);

// File: tb/bmc_audio_tx_tb.sv
module bmc_audio_tx_tb;
    localparam int BLK = 384;
    localparam int NSF = 900;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_wdata = '0;
    logic [15:0] raw_smp = '0, cnc_smp = '0;
    logic        err_flg = 1'b0, itp_flg = 1'b0, user_bit = 1'b0, cstat_bit = 1'b0;
    logic        take_o, right_o, blkst_o, line_o;

    bmc_audio_tx u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .raw_smp(raw_smp), .cnc_smp(cnc_smp), .err_flg(err_flg), .itp_flg(itp_flg),
        .user_bit(user_bit), .cstat_bit(cstat_bit),
        .take_o(take_o), .right_o(right_o), .blkst_o(blkst_o), .line_o(line_o)
    );

    int   n_chk = 0, n_fail = 0;
    bit   done = 1'b0;
    logic cells [64];
    logic prev_lvl = 1'b0;
    int   sfb = 0;
    logic [3:0] cfg_now = '0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] pick(input int i);
        logic [31:0] m;
        m = i * 40503;
        case (i % 5)
            0: return 16'h0000;
            1: return 16'hFFFF;
            2: return 16'h0001 << (i % 16);
            3: return m[15:0];
            default: return ~m[15:0];
        endcase
    endfunction

    task automatic send(input int i, input bit we, input logic [3:0] val);
        logic [15:0] r, c, smp;
        logic        e, t, u, s;
        logic [31:0] ex, got;
        logic [7:0]  pat;
        bit          low, skip, ok;
        int          takes, ones;
        logic [31:0] iv;
        iv = i;
        // at the take cycle
        chk(take_o == 1'b1, "R2 take strobe", {31'b0, take_o}, 32'd1);
        chk(right_o == iv[0] && (sfb % 2 == i % 2 || 1), "R5 right_o", {31'b0, right_o}, {31'b0, 1'(sfb % 2)});
        chk(blkst_o == (sfb == 0), "R5 blkst_o", {31'b0, blkst_o}, {31'b0, 1'(sfb == 0)});
        r = pick(i);
        c = r ^ 16'h5A3C;
        e = iv[1]; t = iv[2]; u = iv[0] ^ iv[3]; s = iv[4];
        raw_smp = r; cnc_smp = c; err_flg = e; itp_flg = t; user_bit = u; cstat_bit = s;
        cfg_we = we; cfg_wdata = val;
        takes = 0;
        for (int k = 0; k < 64; k++) begin
            @(negedge clk);
            cfg_we = 1'b0;
            cells[k] = line_o;
            if (k < 63 && take_o) takes++;
        end
        chk(takes == 0 && take_o, "R2 subframe period", takes, 0);

        low  = (cfg_now[1:0] == 2'b11) && (!we || val[1:0] == 2'b11);
        skip = (cfg_now[1:0] == 2'b11) || (we && val[1:0] == 2'b11);
        if (low) begin
            ones = 0;
            for (int k = 0; k < 64; k++) ones += int'(cells[k]);
            chk(ones == 0, "R8 line held low", ones, 0);
        end else if (!skip) begin
            pat = (sfb == 0) ? 8'hE8 : ((sfb % 2 == 1) ? 8'hE4 : 8'hE2);
            ok = 1'b1;
            for (int j = 0; j < 8; j++) if (cells[j] != (pat[7-j] ^ prev_lvl)) ok = 1'b0;
            chk(ok, "R3 preamble", {24'b0, cells[0], cells[1], cells[2], cells[3],
                cells[4], cells[5], cells[6], cells[7]}, {24'b0, pat ^ {8{prev_lvl}}});
            ok = 1'b1;
            for (int sl = 4; sl < 32; sl++) begin
                if (cells[2*sl] == cells[2*sl-1]) ok = 1'b0;
            end
            chk(ok, "R4 cell boundary toggle", 0, 0);
            got = '0;
            for (int sl = 4; sl < 32; sl++) got[sl] = cells[2*sl] ^ cells[2*sl+1];
            smp = (cfg_now[1:0] == 2'b10) ? c : r;
            ex = '0;
            ex[4] = cfg_now[3] & e;
            ex[5] = cfg_now[3] & t;
            ex[27:12] = smp;
            ex[28] = e; ex[29] = u; ex[30] = s;
            ex[31] = ^ex[30:4];
            chk(got[27:8] == ex[27:8], "R6 R7 R13 audio field", {12'b0, got[27:8]}, {12'b0, ex[27:8]});
            chk(got[7:4] == ex[7:4], "R9 aux slots", {28'b0, got[7:4]}, {28'b0, ex[7:4]});
            chk(got[28] == ex[28], "R10 validity", {31'b0, got[28]}, {31'b0, ex[28]});
            chk(got[30:29] == ex[30:29], "R11 user and status", {30'b0, got[30:29]}, {30'b0, ex[30:29]});
            chk(got[31] == ex[31] && ^got[31:4] == 1'b0, "R12 parity", {31'b0, got[31]}, {31'b0, ex[31]});
        end
        prev_lvl = cells[63];
        sfb = (sfb + 1) % BLK;
        if (we) cfg_now = val;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(line_o == 1'b0, "R1 line in reset", {31'b0, line_o}, 32'd0);
        chk(take_o == 1'b1, "R1 take in reset", {31'b0, take_o}, 32'd1);
        chk(right_o == 1'b0, "R1 right in reset", {31'b0, right_o}, 32'd0);
        chk(blkst_o == 1'b1, "R1 block start in reset", {31'b0, blkst_o}, 32'd1);
        rst_n = 1'b1;
        for (int i = 0; i < NSF; i++) begin
            case (i)
                400:     send(i, 1'b1, 4'b1010);
                600:     send(i, 1'b1, 4'b0001);
                650:     send(i, 1'b1, 4'b0011);
                700:     send(i, 1'b1, 4'b1000);
                default: send(i, 1'b0, 4'b0000);
            endcase
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule